// File: doc/BRIEF.md
# Key-Locked GPIO Pad Mode Controller

This block is a register-mapped bank of general-purpose pins, up to 32 wide, that drives an output value and an output enable for each tri-state pad and reads pad levels back. Each pin has a two-bit drive mode. The mode picks one of four pad behaviours: input only, full push-pull drive, open-drain pulling low, or open-drain pulling high. Software changes the output data through write-one-to-set and write-one-to-clear registers, so it never has to read, modify and write the data word.

The two mode words, and the set and clear aliases that reach them, are write-protected. They accept writes only while a separate lock register is active. Software activates the lock by writing a fixed 16-bit key into the lock register and releases it by writing zero. The lock state is readable in bit 31 of the lock register. Pad input levels pass through a two-stage synchronizer before they reach the data-in register.

Top module: `gpio_mode_bank`

## Requirements
- R1: After reset, both mode words read 0, the lock reads inactive, the output-data bits are 0 and every `pad_oe` bit is 0.
- R2: A pin whose mode pair {mode1,mode0} is 00 has `pad_oe`=0 and `pad_out`=0, whatever its data bit is.
- R3: A pin with mode pair 01 has `pad_oe`=1 and `pad_out` equal to its data bit.
- R4: A pin with mode pair 10 has `pad_out`=0, with `pad_oe`=1 when its data bit is 0 and `pad_oe`=0 when its data bit is 1.
- R5: A pin with mode pair 11 has `pad_out`=1, with `pad_oe`=1 when its data bit is 1 and `pad_oe`=0 when its data bit is 0.
- R6: Writing to the data-set register (0x14) sets the data bits that are 1 in the write data. Writing to the data-clear register (0x18) clears the data bits that are 1 in the write data. Data bits written as 0 keep their value, and both registers read as 0.
- R7: The lock register is at 0x60. Writing 0xD42F to bits [15:0] activates the lock, and writing 0x0000 to those bits releases it. Writing any other value leaves the lock state unchanged. A read of the lock register returns the lock state in bit 31 and 0 in every other bit.
- R8: The mode-word writes (mode1 at 0x08, mode0 at 0x0C) and the alias writes (mode1-clear at 0x50, mode0-set at 0x54, mode0-clear at 0x58) take effect only while the lock is active. Otherwise they are dropped.
- R9: The data-in register (0x04) shows a change on `pad_in` after the second rising clock edge, and not after the first.
- R10: The parameter NPINS (1 to 32) sets the number of pins. Register bits at or above NPINS read as 0 and cannot be written.
- R11: Mode1 reads back at 0x08 and mode0 at 0x0C. The alias offsets, the set and clear offsets, and any unmapped offset read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset for a write or read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pad_in | input | NPINS | Asynchronous pad levels |
| pad_out | output | NPINS | Value driven toward each pad |
| pad_oe | output | NPINS | Output enable for each pad |

## Verification
The bench uses a six-pin bank. For each of the four mode pairs, applied to every pin at once, it steps through all 64 data patterns. This separates the four drive functions: each pattern shows whether output enable and output value follow the data bit, follow its inverse, or stay constant. Lock keys are tried as the right key, a wrong key and zero, in both lock states. Mode writes made while unlocked show whether the protection is working. Writes with all ones and single pad-level steps show the masking of unimplemented bits and the two-edge latency of the synchronizer.

// File: rtl/gpio_bank_pkg.sv
// Shared constants for the GPIO mode bank: register offsets, the lock key
// and the encoding of a pin's drive mode pair.
package gpio_bank_pkg;
    localparam int unsigned REG_W = 32;

    localparam logic [7:0] OFF_DATA_IN   = 8'h04;
    localparam logic [7:0] OFF_MODE1     = 8'h08;
    localparam logic [7:0] OFF_MODE0     = 8'h0C;
    localparam logic [7:0] OFF_DATA_SET  = 8'h14;
    localparam logic [7:0] OFF_DATA_CLR  = 8'h18;
    localparam logic [7:0] OFF_MODE1_CLR = 8'h50;
    localparam logic [7:0] OFF_MODE0_SET = 8'h54;
    localparam logic [7:0] OFF_MODE0_CLR = 8'h58;
    localparam logic [7:0] OFF_LOCK      = 8'h60;

    localparam logic [15:0] LOCK_KEY     = 16'hD42F;
    localparam logic [15:0] LOCK_RELEASE = 16'h0000;

    // {mode1,mode0} encoding of one pin
    typedef enum logic [1:0] {
        PM_INPUT   = 2'b00,
        PM_PUSH    = 2'b01,
        PM_OD_LOW  = 2'b10,
        PM_OD_HIGH = 2'b11
    } pin_mode_e;
endpackage

// File: rtl/gpio_bank_lock.sv
// Mode write-protect lock. Activated by the key in the low half-word,
// released by zero; any other value is ignored.
// Assumes: address compare on the low 8 bits of the offset.
module gpio_bank_lock
    import gpio_bank_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       key_field,
    output logic              lock_active
);
    logic hit;

    // Address decode for the lock register
    always_comb hit = we && (addr[7:0] == OFF_LOCK);

    // Lock state update on key or release value only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_active <= 1'b0;
        end else if (hit) begin
            if (key_field == LOCK_KEY)
                lock_active <= 1'b1;
            else if (key_field == LOCK_RELEASE)
                lock_active <= 1'b0;
        end
    end
endmodule

// File: rtl/gpio_bank_regs.sv
// Mode words and output data word of the bank. Mode writes, direct or
// through aliases, apply only while the lock is active. Data changes through
// write-one set/clear strobes.
// Assumes: NPINS <= 32; upper write-data bits are discarded by the caller.
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  wbits,
    input  logic              lock_active,
    output logic [NPINS-1:0]  mode0,
    output logic [NPINS-1:0]  mode1,
    output logic [NPINS-1:0]  dout
);
    logic mode_we;

    // Mode writes are permitted only under the lock
    always_comb mode_we = we && lock_active;

    // Mode word updates: direct writes and set/clear aliases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode0 <= '0;
            mode1 <= '0;
        end else if (mode_we) begin
            unique case (addr[7:0])
                OFF_MODE1:     mode1 <= wbits;
                OFF_MODE0:     mode0 <= wbits;
                OFF_MODE1_CLR: mode1 <= mode1 & ~wbits;
                OFF_MODE0_SET: mode0 <= mode0 | wbits;
                OFF_MODE0_CLR: mode0 <= mode0 & ~wbits;
                default: ;
            endcase
        end
    end

    // Output data word: write-one-to-set and write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (we) begin
            if (addr[7:0] == OFF_DATA_SET)
                dout <= dout | wbits;
            else if (addr[7:0] == OFF_DATA_CLR)
                dout <= dout & ~wbits;
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
// Multi-stage synchronizer for asynchronous pad inputs.
// Assumes: STAGES >= 2; each bit is synchronized on its own.
module gpio_in_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift chain of flops, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d_async;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    // Last stage is the synchronized value
    always_comb q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_drive.sv
// Per-pin pad driver: maps a mode pair and a data bit to output value and
// output enable.
// Assumes: purely combinational; the pad cell does the tri-stating.
module gpio_pad_drive
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic [NPINS-1:0] mode0,
    input  logic [NPINS-1:0] mode1,
    input  logic [NPINS-1:0] dout,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_mode_e pm;

        // Pin mode decode
        always_comb pm = pin_mode_e'({mode1[i], mode0[i]});

        // Drive function of the four modes
        always_comb begin
            unique case (pm)
                PM_INPUT:   begin pad_out[i] = 1'b0;    pad_oe[i] = 1'b0;     end
                PM_PUSH:    begin pad_out[i] = dout[i]; pad_oe[i] = 1'b1;     end
                PM_OD_LOW:  begin pad_out[i] = 1'b0;    pad_oe[i] = ~dout[i]; end
                PM_OD_HIGH: begin pad_out[i] = 1'b1;    pad_oe[i] = dout[i];  end
                default:    begin pad_out[i] = 1'b0;    pad_oe[i] = 1'b0;     end
            endcase
        end
    end
endmodule

// File: rtl/gpio_mode_bank.sv
// Top of the GPIO mode bank: the lock, the registers, the pad drivers and the
// input synchronizer, plus the register read mux.
// Assumes: 1 <= NPINS <= 32; reads are combinational on reg_addr.
module gpio_mode_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);
    localparam int unsigned SYNC_STAGES = 2;

    logic             lock_active;
    logic [NPINS-1:0] mode0_r;
    logic [NPINS-1:0] mode1_r;
    logic [NPINS-1:0] dout_r;
    logic [NPINS-1:0] din_sync;

    gpio_bank_lock #(.ADDR_W(ADDR_W)) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (reg_we),
        .addr        (reg_addr),
        .key_field   (reg_wdata[15:0]),
        .lock_active (lock_active)
    );

    gpio_bank_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (reg_we),
        .addr        (reg_addr),
        .wbits       (reg_wdata[NPINS-1:0]),
        .lock_active (lock_active),
        .mode0       (mode0_r),
        .mode1       (mode1_r),
        .dout        (dout_r)
    );

    gpio_pad_drive #(.NPINS(NPINS)) u_drive (
        .mode0   (mode0_r),
        .mode1   (mode1_r),
        .dout    (dout_r),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    gpio_in_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .q_sync  (din_sync)
    );

    // Register read mux; unimplemented bits and offsets read zero
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr[7:0])
            OFF_DATA_IN: reg_rdata[NPINS-1:0] = din_sync;
            OFF_MODE1:   reg_rdata[NPINS-1:0] = mode1_r;
            OFF_MODE0:   reg_rdata[NPINS-1:0] = mode0_r;
            OFF_LOCK:    reg_rdata[31]        = lock_active;
            default: ;
        endcase
    end
endmodule

// File: rtl/gpio_mode_bank_chk.sv
// Property checker for gpio_mode_bank, bound to every instance of the top.
// Relates the register state to the pad driver outputs and the lock over time.
module gpio_mode_bank_chk #(
    parameter int unsigned NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lock_active,
    input logic [NPINS-1:0] mode0_r,
    input logic [NPINS-1:0] mode1_r,
    input logic [NPINS-1:0] dout_r,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic             reg_we,
    input logic [7:0]       addr8,
    input logic [15:0]      key_field
);
    AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((~mode1_r & ~mode0_r) & pad_oe) == '0); // R2
    AST_PUSH_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ((~mode1_r & mode0_r) & (~pad_oe | (pad_out ^ dout_r))) == '0); // R3
    AST_ODLOW_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode1_r & ~mode0_r) & pad_out) == '0); // R4
    AST_ODHIGH_NEVER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode1_r & mode0_r) & ~pad_out) == '0); // R5
    AST_MODE_HELD_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_active |=> ($stable(mode0_r) && $stable(mode1_r))); // R8
    AST_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && addr8 == 8'h60 && key_field == 16'hD42F) |=> lock_active); // R7
    AST_ZERO_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && addr8 == 8'h60 && key_field == 16'h0000) |=> !lock_active); // R7
endmodule

bind gpio_mode_bank gpio_mode_bank_chk #(.NPINS(NPINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lock_active (lock_active),
    .mode0_r     (mode0_r),
    .mode1_r     (mode1_r),
    .dout_r      (dout_r),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .reg_we      (reg_we),
    .addr8       (reg_addr[7:0]),
    .key_field   (reg_wdata[15:0])
);

// File: tb/tb_gpio_mode_bank.sv
module tb_gpio_mode_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 6;
    localparam logic [31:0] PMASK = 32'h3F;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    gpio_mode_bank #(.NPINS(NP), .ADDR_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        logic [31:0] v;
        logic [NP-1:0] eo, ee;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h08, v); check("R1 mode1", v, 0);
        rd(8'h0C, v); check("R1 mode0", v, 0);
        rd(8'h60, v); check("R1 lock", v, 0);
        check("R1 oe", {26'b0, pad_oe}, 0);

        // R8 mode writes dropped while unlocked
        wr(8'h0C, 32'h3F); rd(8'h0C, v); check("R8 unlocked mode0", v, 0);
        wr(8'h54, 32'h3F); rd(8'h0C, v); check("R8 unlocked alias", v, 0);

        // R7 lock keys
        wr(8'h60, 32'h1234); rd(8'h60, v); check("R7 bad key", v, 0);
        wr(8'h60, 32'hD42F); rd(8'h60, v); check("R7 key", v, 32'h8000_0000);
        wr(8'h60, 32'h1234); rd(8'h60, v); check("R7 bad key locked", v, 32'h8000_0000);
        wr(8'h60, 32'h0);    rd(8'h60, v); check("R7 release", v, 0);
        wr(8'h60, 32'hD42F);

        // R10 unimplemented bits, R11 readback and aliases
        wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, v); check("R10 mode0 mask", v, PMASK);
        wr(8'h58, 32'h05); rd(8'h0C, v); check("R11 mode0 clear alias", v, 32'h3A);
        wr(8'h54, 32'h01); rd(8'h0C, v); check("R11 mode0 set alias", v, 32'h3B);
        wr(8'h08, 32'h2C); rd(8'h08, v); check("R11 mode1", v, 32'h2C);
        wr(8'h50, 32'h0C); rd(8'h08, v); check("R11 mode1 clear alias", v, 32'h20);
        rd(8'h54, v); check("R11 alias reads 0", v, 0);
        rd(8'h20, v); check("R11 unmapped", v, 0);
        rd(8'h14, v); check("R6 set reads 0", v, 0);
        rd(8'h18, v); check("R6 clear reads 0", v, 0);

        // R6 set/clear with zero bits unchanged, observed in push-pull mode
        wr(8'h08, 0); wr(8'h0C, 32'h3F); wr(8'h18, 32'h3F);
        wr(8'h14, 32'h05); check("R6 set", {26'b0, pad_out}, 32'h05);
        wr(8'h14, 32'h10); check("R6 set keeps others", {26'b0, pad_out}, 32'h15);
        wr(8'h18, 32'h04); check("R6 clear keeps others", {26'b0, pad_out}, 32'h11);

        // R2-R5 sweep all modes over all data patterns
        for (int m = 0; m < 4; m++) begin
            wr(8'h08, m[1] ? 32'hFF : 32'h0);
            wr(8'h0C, m[0] ? 32'hFF : 32'h0);
            for (int p = 0; p < 64; p++) begin
                wr(8'h14, p);
                wr(8'h18, ~p);
                case (m)
                    0: begin ee = '0;        eo = '0;        end
                    1: begin ee = '1;        eo = p[NP-1:0]; end
                    2: begin ee = ~p[NP-1:0]; eo = '0;       end
                    default: begin ee = p[NP-1:0]; eo = '1;  end
                endcase
                check(m == 0 ? "R2 oe" : m == 1 ? "R3 oe" : m == 2 ? "R4 oe" : "R5 oe",
                      {26'b0, pad_oe}, {26'b0, ee});
                check(m == 0 ? "R2 out" : m == 1 ? "R3 out" : m == 2 ? "R4 out" : "R5 out",
                      {26'b0, pad_out}, {26'b0, eo});
            end
        end

        // R8 locked state released then mode write dropped
        wr(8'h60, 0); wr(8'h08, 0); rd(8'h08, v); check("R8 mode1 held", v, PMASK);

        // R9 two-edge synchronizer latency
        @(negedge clk); pad_in = 6'h2B;
        @(negedge clk); rd(8'h04, v); check("R9 one edge", v, 0);
        @(negedge clk); rd(8'h04, v); check("R9 two edges", v, 32'h2B);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule